// File: doc/BRIEF.md
# Serial Memory-Access and Power-Command Bridge

This block sits behind a four-wire SPI slave port (mode 0) and converts each select-framed transaction into one of three actions: a burst of byte writes into a 22-bit address space, a burst of byte reads from that space returned on MISO, or a three-byte command frame that changes a power-state register, two clock-selection outputs or fires a core reset pulse. The first two bits on the wire pick the action. For memory traffic the next 22 bits carry the start address, which then advances by one for every byte moved.

All SPI signals are brought into the system clock domain through synchronizer stages, and the whole block runs on that clock. The system clock must be at least eight times the SPI clock, so that a MISO change made after a detected falling edge is settled before the next rising edge. The memory side is a simple strobe interface. A write is one `mem_wr` cycle carrying address and data. A read is one `mem_rd` cycle, and the data is sampled on `mem_rdata` in the following cycle. Reads are fetched one byte ahead, during the middle of the preceding byte.

Top module: `spi_mem_bridge`

## Requirements
- R1: After reset, `pwr_state` is 0 (active), `clk_ext`, `clk_36m`, `core_rst`, `mem_wr`, `mem_rd` and `spi_miso` are all 0.
- R2: A frame whose first byte has bits [7:6] = 10 is a write. Bits [5:0] of byte 0 followed by bytes 1 and 2 form the address, most significant first. Every later complete byte gives one `mem_wr` pulse with that byte on `mem_wdata` and the current address on `mem_addr`. Bits are received most significant first, sampled on rising SCLK.
- R3: The address advances by one after each byte transferred and wraps from 0x3FFFFF to 0x000000, for both reads and writes.
- R4: A frame with leading bits 00 is a read. After the three address bytes and one dummy byte, each following byte returns on MISO the data of consecutive addresses, starting at the given address, most significant bit first. The data is valid at each rising SCLK edge. `mem_rdata` is sampled one system cycle after `mem_rd`.
- R5: In the data phase of a read, MOSI content has no effect, and no `mem_wr` is produced.
- R6: A read frame with N returned bytes produces exactly N+1 `mem_rd` pulses (one look-ahead). A read frame that ends before its dummy byte produces none. A frame with leading bits 11 produces no memory strobe. `mem_wr` and `mem_rd` are never high together.
- R7: A command frame of exactly three bytes, an opcode with leading bits 01 followed by two zero bytes, takes effect after select rises. 0x41 sets `pwr_state` to 1 (standby), 0x42 to 2 (sleep) and 0x50 to 3 (power-down). `pwr_state` changes only while select is high.
- R8: A frame of exactly three zero bytes sets `pwr_state` to 0 (active) from any state.
- R9: Opcode 0x44 sets `clk_ext` to 1. Opcode 0x61 sets `clk_36m` to 1 and 0x62 clears it.
- R10: Opcode 0x68 drives `core_rst` high for exactly 16 consecutive system clocks.
- R11: A command frame with a nonzero second or third byte, a length other than three bytes, or an opcode not listed in R7 to R10 leaves `pwr_state`, `clk_ext` and `clk_36m` unchanged.
- R12: Raising select in the middle of a byte discards the partial byte (no strobe). The next frame starts cleanly at bit 7 of byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| mem_addr | output | 22 | Byte address for the current strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pwr_state | output | 2 | 0 active, 1 standby, 2 sleep, 3 power-down |
| clk_ext | output | 1 | External clock source selected |
| clk_36m | output | 1 | Reduced PLL frequency selected |
| core_rst | output | 1 | Core reset pulse |

## Verification
A bit counter that is off by one shows at once as a shifted MISO byte, and as a write byte built from two neighbouring bytes on the first `mem_wr` of the frame. A wrong address counter shows on the next strobe, one byte time later, as a `mem_addr` that does not step by one or does not wrap at the top of the space. Errors in the command decoder or the power register show a few system clocks after select rises, as a wrong `pwr_state` or clock output. The same holds for a malformed frame that is wrongly acted on. A wrong reset-pulse counter shows within sixteen cycles as a `core_rst` that is too short or too long.

// File: rtl/spi_bridge_pkg.sv
// Shared encodings for the serial memory-access bridge.
package spi_bridge_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE  = 2'd0,
        PWR_STANDBY = 2'd1,
        PWR_SLEEP   = 2'd2,
        PWR_DOWN    = 2'd3
    } pwr_e;

    // Leading two bits of the first byte of a frame.
    typedef enum logic [1:0] {
        XK_READ  = 2'b00,
        XK_CMD   = 2'b01,
        XK_WRITE = 2'b10,
        XK_NONE  = 2'b11
    } xkind_e;

    localparam logic [7:0] OP_WAKE     = 8'h00;
    localparam logic [7:0] OP_STANDBY  = 8'h41;
    localparam logic [7:0] OP_SLEEP    = 8'h42;
    localparam logic [7:0] OP_PWRDOWN  = 8'h50;
    localparam logic [7:0] OP_CLK_EXT  = 8'h44;
    localparam logic [7:0] OP_CLK_48   = 8'h62;
    localparam logic [7:0] OP_CLK_36   = 8'h61;
    localparam logic [7:0] OP_CORE_RST = 8'h68;

endpackage

// File: rtl/spi_edge_sync.sv
// Brings SCLK, select and MOSI into the system clock domain and derives
// one-cycle edge pulses. Assumes the system clock is at least eight times
// the SPI clock; MOSI passes through the same number of stages as SCLK so
// the two stay aligned. STAGES must be 2 or more.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic sel,
    output logic frame_end
);

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mo_p;
    logic              sck_last;
    logic              cs_last;

    // Synchronizer chains, select resets to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
            mo_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sclk_i};
            cs_p  <= {cs_p[STAGES-2:0], cs_n_i};
            mo_p  <= {mo_p[STAGES-2:0], mosi_i};
        end
    end

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_last <= 1'b0;
            cs_last  <= 1'b1;
        end else begin
            sck_last <= sck_p[STAGES-1];
            cs_last  <= cs_p[STAGES-1];
        end
    end

    assign sclk_rise = sck_p[STAGES-1] & ~sck_last;
    assign sclk_fall = ~sck_p[STAGES-1] & sck_last;
    assign mosi_s    = mo_p[STAGES-1];
    assign sel       = ~cs_p[STAGES-1];
    assign frame_end = cs_p[STAGES-1] & ~cs_last;

endmodule

// File: rtl/spi_byte_shifter.sv
// Serial-to-byte receiver and byte-to-serial transmitter, MSB first, mode 0.
// Receive samples on detected rising edges; transmit advances on detected
// falling edges inside a byte. A load made at the last rising edge of a byte
// is presented before the next byte's first rising edge. All state clears
// while select is inactive, which drops any partial byte.
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         mosi_s,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         byte_done,
    output logic         mid_pulse,
    output logic [W-1:0] rx_byte,
    output logic         miso
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
    localparam logic [CW-1:0] MID_BIT  = CW'(W / 2 - 1);

    logic [CW-1:0] bit_cnt;
    logic [W-2:0]  rx_sh;
    logic [W-1:0]  tx_sh;

    // Receive shift register and bit position within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (sclk_rise) begin
            rx_sh   <= {rx_sh[W-3:0], mosi_s};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Transmit register: load at byte boundary, shift on falls inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (sclk_fall && bit_cnt != '0) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
    end

    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = sel & sclk_rise & (bit_cnt == LAST_BIT);
    assign mid_pulse = sel & sclk_rise & (bit_cnt == MID_BIT);
    assign miso      = tx_sh[W-1];

endmodule

// File: rtl/spi_xact_ctrl.sv
// Frame sequencer for memory traffic. Collects the header bytes, holds the
// running address and issues write and read strobes. Reads are fetched one
// byte ahead at the middle of the preceding byte (the dummy byte for the
// first one), so data is waiting when the byte boundary arrives. Assumes
// mem_rdata is valid one cycle after mem_rd.
module spi_xact_ctrl
    import spi_bridge_pkg::*;
#(
    parameter int AW = 22,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          byte_done,
    input  logic          mid_pulse,
    input  logic [W-1:0]  rx_byte,
    input  logic [W-1:0]  mem_rdata,
    output logic          load,
    output logic [W-1:0]  load_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_rd
);

    localparam int HDR  = (AW + 2 + W - 1) / W;
    localparam int IDXW = $clog2(HDR + 2);
    localparam logic [IDXW-1:0] IDX_HDR  = IDXW'(HDR);
    localparam logic [IDXW-1:0] IDX_DATA = IDXW'(HDR + 1);

    logic [IDXW-1:0] idx;
    xkind_e          kind;
    logic [AW-1:0]   addr;
    logic            rd_pend;
    logic [W-1:0]    pre_buf;
    logic            in_body;

    assign in_body = (idx >= IDX_HDR);

    // Header collection, address counter and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            kind      <= XK_NONE;
            addr      <= '0;
            mem_addr  <= '0;
            mem_wr    <= 1'b0;
            mem_wdata <= '0;
            mem_rd    <= 1'b0;
        end else begin
            mem_wr <= 1'b0;
            mem_rd <= 1'b0;
            if (!sel) begin
                idx  <= '0;
                kind <= XK_NONE;
                addr <= '0;
            end else if (byte_done) begin
                if (!in_body) begin
                    addr <= {addr[AW-W-1:0], rx_byte};
                    if (idx == '0) begin
                        kind <= xkind_e'(rx_byte[W-1:W-2]);
                    end
                    idx <= idx + 1'b1;
                end else begin
                    idx <= IDX_DATA;
                    if (kind == XK_WRITE) begin
                        mem_wr    <= 1'b1;
                        mem_addr  <= addr;
                        mem_wdata <= rx_byte;
                        addr      <= addr + 1'b1;
                    end
                end
            end else if (mid_pulse && kind == XK_READ && in_body) begin
                mem_rd   <= 1'b1;
                mem_addr <= addr;
                addr     <= addr + 1'b1;
            end
        end
    end

    // Look-ahead buffer filled one cycle after each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            pre_buf <= '0;
        end else begin
            rd_pend <= mem_rd;
            if (rd_pend) begin
                pre_buf <= mem_rdata;
            end
        end
    end

    assign load      = byte_done & (kind == XK_READ) & in_body;
    assign load_data = pre_buf;

endmodule

// File: rtl/spi_cmd_decoder.sv
// Watches every frame for the three-byte command form (opcode then zero
// bytes) and, when select rises, applies it to the power-state register,
// the clock-selection flags or the core reset pulse counter. Frames of any
// other length, with nonzero trailing bytes or unknown opcodes, are ignored.
module spi_cmd_decoder
    import spi_bridge_pkg::*;
#(
    parameter int W          = 8,
    parameter int CMD_LEN    = 3,
    parameter int RST_CYCLES = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         byte_done,
    input  logic [W-1:0] rx_byte,
    input  logic         frame_end,
    output pwr_e         pwr_state,
    output logic         clk_ext,
    output logic         clk_36m,
    output logic         core_rst
);

    localparam int CW  = $clog2(CMD_LEN + 2);
    localparam int RCW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0]  CNT_CMD  = CW'(CMD_LEN);
    localparam logic [CW-1:0]  CNT_OVER = CW'(CMD_LEN + 1);
    localparam logic [RCW-1:0] RST_LOAD = RCW'(RST_CYCLES);

    logic [CW-1:0]  cnt;
    logic [W-1:0]   op;
    logic           tail_zero;
    logic           cmd_ok;
    logic [RCW-1:0] rst_cnt;

    // Byte counting, opcode capture and trailing-zero tracking per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            cnt       <= '0;
            op        <= '0;
            tail_zero <= 1'b1;
        end else if (byte_done) begin
            if (cnt == '0) begin
                op <= rx_byte;
            end else if (rx_byte != '0) begin
                tail_zero <= 1'b0;
            end
            if (cnt != CNT_OVER) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign cmd_ok = frame_end & (cnt == CNT_CMD) & tail_zero;

    // Command execution at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_state <= PWR_ACTIVE;
            clk_ext   <= 1'b0;
            clk_36m   <= 1'b0;
        end else if (cmd_ok) begin
            case (op)
                OP_WAKE:    pwr_state <= PWR_ACTIVE;
                OP_STANDBY: pwr_state <= PWR_STANDBY;
                OP_SLEEP:   pwr_state <= PWR_SLEEP;
                OP_PWRDOWN: pwr_state <= PWR_DOWN;
                OP_CLK_EXT: clk_ext   <= 1'b1;
                OP_CLK_36:  clk_36m   <= 1'b1;
                OP_CLK_48:  clk_36m   <= 1'b0;
                default:    ;
            endcase
        end
    end

    // Core reset pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt <= '0;
        end else if (cmd_ok && op == OP_CORE_RST) begin
            rst_cnt <= RST_LOAD;
        end else if (rst_cnt != '0) begin
            rst_cnt <= rst_cnt - 1'b1;
        end
    end

    assign core_rst = (rst_cnt != '0);

endmodule

// File: rtl/spi_mem_bridge.sv
// Top level of the serial memory-access bridge. Connects the synchronizer,
// the byte shifter, the memory frame sequencer and the command decoder.
// Assumes the system clock runs at least eight times the SPI clock.
module spi_mem_bridge
    import spi_bridge_pkg::*;
#(
    parameter int ADDR_W          = 22,
    parameter int DATA_W          = 8,
    parameter int SYNC_STAGES     = 2,
    parameter int CMD_BYTES       = 3,
    parameter int CORE_RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        pwr_state,
    output logic              clk_ext,
    output logic              clk_36m,
    output logic              core_rst
);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              mosi_s;
    logic              sel;
    logic              frame_end;
    logic              byte_done;
    logic              mid_pulse;
    logic [DATA_W-1:0] rx_byte;
    logic              load;
    logic [DATA_W-1:0] load_data;
    pwr_e              pwr;

    spi_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .sel       (sel),
        .frame_end (frame_end)
    );

    spi_byte_shifter #(
        .W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .load      (load),
        .load_data (load_data),
        .byte_done (byte_done),
        .mid_pulse (mid_pulse),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_xact_ctrl #(
        .AW (ADDR_W),
        .W  (DATA_W)
    ) u_xact (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .byte_done (byte_done),
        .mid_pulse (mid_pulse),
        .rx_byte   (rx_byte),
        .mem_rdata (mem_rdata),
        .load      (load),
        .load_data (load_data),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd)
    );

    spi_cmd_decoder #(
        .W          (DATA_W),
        .CMD_LEN    (CMD_BYTES),
        .RST_CYCLES (CORE_RST_CYCLES)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .frame_end (frame_end),
        .pwr_state (pwr),
        .clk_ext   (clk_ext),
        .clk_36m   (clk_36m),
        .core_rst  (core_rst)
    );

    assign pwr_state = pwr;

endmodule

// File: rtl/spi_mem_bridge_chk.sv
// Property checker for the bridge, attached to every instance by bind.
module spi_mem_bridge_chk #(
    parameter int ADDR_W          = 22,
    parameter int CORE_RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        pwr_state,
    input logic              core_rst
);

    localparam int HCW = $clog2(CORE_RST_CYCLES + 2) + 1;

    logic [ADDR_W-1:0] wr_prev;
    logic [ADDR_W-1:0] rd_prev;
    logic              wr_seen;
    logic              rd_seen;
    logic [HCW-1:0]    hi_cnt;

    // Last strobe address within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            wr_seen <= 1'b0;
            rd_seen <= 1'b0;
            wr_prev <= '0;
            rd_prev <= '0;
        end else begin
            if (mem_wr) begin
                wr_seen <= 1'b1;
                wr_prev <= mem_addr;
            end
            if (mem_rd) begin
                rd_seen <= 1'b1;
                rd_prev <= mem_addr;
            end
        end
    end

    // Length of the current core reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd}));

    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_wr_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && wr_seen) |-> (mem_addr == ADDR_W'(wr_prev + 1'b1)));

    assert_rd_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && rd_seen) |-> (mem_addr == ADDR_W'(rd_prev + 1'b1)));

    assert_pwr_idle_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_state) |-> spi_cs_n);

    assert_core_rst_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (hi_cnt < HCW'(CORE_RST_CYCLES)));

    assert_core_rst_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (hi_cnt == HCW'(CORE_RST_CYCLES)));

endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(
    .ADDR_W          (ADDR_W),
    .CORE_RST_CYCLES (CORE_RST_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .pwr_state (pwr_state),
    .core_rst  (core_rst)
);

// File: tb/sim_spi_mem_bridge.sv
// Self-checking bench: directed corner cases plus seeded random bursts.
module sim_spi_mem_bridge;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 50;  // SPI half period, ten system clocks per SPI clock

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [21:0] mem_addr;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic [1:0]  pwr_state;
    logic        clk_ext;
    logic        clk_36m;
    logic        core_rst;

    int nchecks = 0;
    int nerrs   = 0;
    int wr_tot  = 0;
    int rd_tot  = 0;
    int rst_hi  = 0;
    logic [21:0] wa [0:511];
    logic [7:0]  wd [0:511];
    logic [7:0]  txb [0:31];
    logic [7:0]  rxb [0:31];

    always #5 clk = ~clk;

    spi_mem_bridge u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .pwr_state (pwr_state),
        .clk_ext   (clk_ext),
        .clk_36m   (clk_36m),
        .core_rst  (core_rst)
    );

    function automatic logic [7:0] rd_pat(input logic [21:0] a);
        return a[7:0] ^ {a[13:8], a[21:20]} ^ 8'hA5;
    endfunction

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= rd_pat(mem_addr);
    end

    // Strobe and pulse monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_wr) begin
                if (wr_tot < 512) begin
                    wa[wr_tot] <= mem_addr;
                    wd[wr_tot] <= mem_wdata;
                end
                wr_tot <= wr_tot + 1;
            end
            if (mem_rd) rd_tot <= rd_tot + 1;
            if (core_rst) rst_hi <= rst_hi + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerrs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] t, input int nb, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i >= 8 - nb; i--) begin
            spi_mosi = t[i];
            #HALF;
            spi_sclk = 1'b1;
            r[i] = spi_miso;
            #HALF;
            spi_sclk = 1'b0;
        end
    endtask

    task automatic run_frame(input int n);
        logic [7:0] r;
        @(negedge clk);
        spi_cs_n = 1'b0;
        #HALF;
        for (int i = 0; i < n; i++) begin
            spi_bits(txb[i], 8, r);
            rxb[i] = r;
        end
        #HALF;
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr_frame(input logic [21:0] a, input int n, input string req);
        int base;
        logic [21:0] ea;
        base = wr_tot;
        txb[0] = {2'b10, a[21:16]};
        txb[1] = a[15:8];
        txb[2] = a[7:0];
        for (int i = 0; i < n; i++) txb[3+i] = 8'($urandom);
        run_frame(3 + n);
        check(wr_tot - base == n, req, wr_tot - base, n);
        for (int i = 0; i < n; i++) begin
            ea = a + 22'(i);
            check(wa[base+i] == ea, req, wa[base+i], ea);
            check(wd[base+i] == txb[3+i], req, wd[base+i], txb[3+i]);
        end
    endtask

    task automatic rd_frame(input logic [21:0] a, input int n, input string req);
        int wbase;
        int rbase;
        logic [7:0] ev;
        wbase = wr_tot;
        rbase = rd_tot;
        txb[0] = {2'b00, a[21:16]};
        txb[1] = a[15:8];
        txb[2] = a[7:0];
        for (int i = 0; i <= n; i++) txb[3+i] = 8'($urandom);  // dummy and random MOSI
        run_frame(4 + n);
        for (int i = 0; i < n; i++) begin
            ev = rd_pat(a + 22'(i));
            check(rxb[4+i] == ev, req, rxb[4+i], ev);
        end
        check(wr_tot == wbase, "R5", wr_tot - wbase, 0);
        check(rd_tot - rbase == n + 1, "R6", rd_tot - rbase, n + 1);
    endtask

    task automatic cmd_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int n);
        txb[0] = b0;
        txb[1] = b1;
        txb[2] = b2;
        txb[3] = 8'h00;
        run_frame(n);
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int wb;
        int rb;
        int hb;
        logic [7:0] r;
        logic [21:0] a;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pwr_state == 2'd0, "R1", pwr_state, 0);
        check({clk_ext, clk_36m, core_rst} == 3'b000, "R1", {clk_ext, clk_36m, core_rst}, 0);
        check({mem_wr, mem_rd, spi_miso} == 3'b000, "R1", {mem_wr, mem_rd, spi_miso}, 0);

        // R2 directed write, R3 wrap for writes and reads
        wr_frame(22'h012345, 3, "R2");
        wr_frame(22'h3FFFFE, 3, "R3");
        rd_frame(22'h00ABCD, 4, "R4");
        rd_frame(22'h3FFFFF, 2, "R3");

        // R6: read frame ending before dummy byte, and a frame with leading 11
        wb = wr_tot; rb = rd_tot;
        txb[0] = 8'h00; txb[1] = 8'h12; txb[2] = 8'h34;
        run_frame(3);
        check(rd_tot == rb, "R6", rd_tot - rb, 0);
        txb[0] = 8'hC0; txb[1] = 8'h00; txb[2] = 8'h10; txb[3] = 8'h55; txb[4] = 8'hAA;
        run_frame(5);
        check(rd_tot == rb && wr_tot == wb, "R6", (rd_tot - rb) + (wr_tot - wb), 0);

        // R7 and R8: power commands
        cmd_frame(8'h41, 8'h00, 8'h00, 3);
        check(pwr_state == 2'd1, "R7", pwr_state, 1);
        cmd_frame(8'h42, 8'h00, 8'h00, 3);
        check(pwr_state == 2'd2, "R7", pwr_state, 2);
        cmd_frame(8'h00, 8'h00, 8'h00, 3);
        check(pwr_state == 2'd0, "R8", pwr_state, 0);
        cmd_frame(8'h50, 8'h00, 8'h00, 3);
        check(pwr_state == 2'd3, "R7", pwr_state, 3);
        cmd_frame(8'h00, 8'h00, 8'h00, 3);
        check(pwr_state == 2'd0, "R8", pwr_state, 0);

        // R9: clock selection
        cmd_frame(8'h44, 8'h00, 8'h00, 3);
        check(clk_ext == 1'b1, "R9", clk_ext, 1);
        cmd_frame(8'h61, 8'h00, 8'h00, 3);
        check(clk_36m == 1'b1, "R9", clk_36m, 1);
        cmd_frame(8'h62, 8'h00, 8'h00, 3);
        check(clk_36m == 1'b0 && clk_ext == 1'b1, "R9", {clk_ext, clk_36m}, 2'b10);

        // R10: core reset pulse width
        hb = rst_hi;
        cmd_frame(8'h68, 8'h00, 8'h00, 3);
        repeat (40) @(negedge clk);
        check(rst_hi - hb == 16, "R10", rst_hi - hb, 16);
        check(core_rst == 1'b0, "R10", core_rst, 0);

        // R11: malformed command frames
        cmd_frame(8'h41, 8'h00, 8'h00, 3);
        cmd_frame(8'h42, 8'h01, 8'h00, 3);
        check(pwr_state == 2'd1, "R11", pwr_state, 1);
        cmd_frame(8'h42, 8'h00, 8'h00, 4);
        check(pwr_state == 2'd1, "R11", pwr_state, 1);
        cmd_frame(8'h42, 8'h00, 8'h00, 2);
        check(pwr_state == 2'd1, "R11", pwr_state, 1);
        cmd_frame(8'h45, 8'h00, 8'h00, 3);
        check(pwr_state == 2'd1 && clk_ext && !clk_36m, "R11", {pwr_state, clk_ext, clk_36m}, 4'b0110);
        cmd_frame(8'h00, 8'h00, 8'h00, 3);

        // R12: abort in the middle of a data byte
        wb = wr_tot;
        @(negedge clk);
        spi_cs_n = 1'b0;
        #HALF;
        spi_bits(8'h80, 8, r);
        spi_bits(8'h02, 8, r);
        spi_bits(8'h00, 8, r);
        spi_bits(8'h3C, 8, r);
        spi_bits(8'hFF, 4, r);
        #HALF;
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
        check(wr_tot - wb == 1, "R12", wr_tot - wb, 1);
        check(wd[wb] == 8'h3C && wa[wb] == 22'h000200, "R12", {wa[wb], wd[wb]}, {22'h000200, 8'h3C});
        wr_frame(22'h000040, 1, "R12");

        // Random bursts
        for (int it = 0; it < 24; it++) begin
            a = 22'($urandom);
            if (it % 6 == 5) a = 22'h3FFFFD;
            if ($urandom % 2 == 0) wr_frame(a, 1 + int'($urandom % 5), "R2");
            else rd_frame(a, 1 + int'($urandom % 5), "R4");
        end
        finish_up();
    end

endmodule